// File: doc/BRIEF.md
# Overlapping 0110011 Serial Pattern Detector

This block watches a single serial data line and accepts one bit on every rising clock edge. It flags each time the accepted bits, oldest first, form the pattern 0110011. Occurrences may share bits: the trailing 011 of one match can open the next match. The block drives two detect flags. The registered flag rises for one cycle after the completing bit has been accepted. The combinational flag is high during the cycle in which the completing bit is presented on the input.

The machine has eight states, and each state records how many leading pattern bits are currently matched (zero to seven). The 3-bit state code goes out on a port so that a neighbour can decode the match depth directly. The codes were assigned so that most related states differ in a single bit. A synchronous reset returns the machine to the zero-match state.

Top module: `serial_pattern_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is the zero-match state. After that edge, `state_code` is 000 and `det_reg` is 0. `det_comb` is also 0, because it can only be high in the six-match state.
- R2: `det_comb` is 1 exactly when the six bits accepted most recently are 011001 (oldest first) and `din` is 1, counting only bits accepted since the last reset.
- R3: `det_reg` is 1 for exactly one cycle. That cycle directly follows the edge that accepted a bit for which `det_comb` was 1.
- R4: Matches may overlap. After a match, an accepted 0 leaves four bits matched (code 010). A following 011 then completes another match, so 0110011 followed by 0011 and then 0011 again gives three detections.
- R5: `state_code` gives the number of leading pattern bits matched by the longest suffix of the accepted stream. The codes are: 0 = 000, 1 = 111, 2 = 101, 3 = 001, 4 = 010, 5 = 110, 6 = 011, 7 (full match) = 100.
- R6: `det_reg` and `det_comb` are never 1 in the same cycle.
- R7: While `rst` is high, `din` has no effect. The state stays at 000 no matter what bits are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit is accepted per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit |
| det_reg | output | 1 | Registered detect flag, high in the full-match state |
| det_comb | output | 1 | Combinational detect flag, high while the completing bit is on `din` |
| state_code | output | 3 | Current state code, giving the match depth as listed in R5 |

## Verification
The embedded properties are checked on every cycle. They cover these points:
- the return to code 000 after any reset edge;
- the one-cycle lag from the combinational flag to the registered flag;
- the exits from the full-match state, including the overlap arc to 010;
- the mutual exclusion of the two flags.

Whether the flags fire on exactly the right bits of an arbitrary stream can only be shown by the bench scenarios. The same holds for the match-depth code after every prefix. The bench compares every cycle against a shift-register history model, using random streams with single and overlapping embedded matches, a reset in mid-pattern, and the explicit back-to-back overlap chain.

// File: rtl/seqdet_pkg.sv
`timescale 1ns/1ps
package seqdet_pkg;
    localparam int PAT_LEN = 7;
    localparam int ST_W    = 3;
    localparam logic [PAT_LEN-1:0] PATTERN = 7'b0110011;

    // Names give the number of leading pattern bits matched.
    typedef enum logic [ST_W-1:0] {
        ST_M0  = 3'b000,
        ST_M1  = 3'b111,
        ST_M2  = 3'b101,
        ST_M3  = 3'b001,
        ST_M4  = 3'b010,
        ST_M5  = 3'b110,
        ST_M6  = 3'b011,
        ST_HIT = 3'b100
    } sd_state_e;

    typedef struct packed {
        sd_state_e state;
    } sd_regs_t;
endpackage

// File: rtl/sd_next.sv
`timescale 1ns/1ps
module sd_next
    import seqdet_pkg::*;
(
    input  sd_state_e cur,
    input  logic      bit_in,
    output sd_state_e nxt
);
    // Each arc leads to the longest suffix that is still a pattern prefix.
    always_comb begin
        unique case (cur)
            ST_M0:   nxt = bit_in ? ST_M0  : ST_M1;
            ST_M1:   nxt = bit_in ? ST_M2  : ST_M1;
            ST_M2:   nxt = bit_in ? ST_M3  : ST_M1;
            ST_M3:   nxt = bit_in ? ST_M0  : ST_M4;
            ST_M4:   nxt = bit_in ? ST_M2  : ST_M5;
            ST_M5:   nxt = bit_in ? ST_M6  : ST_M1;
            ST_M6:   nxt = bit_in ? ST_HIT : ST_M1;
            ST_HIT:  nxt = bit_in ? ST_M0  : ST_M4;  // trailing 0110 kept
            default: nxt = ST_M0;
        endcase
    end
endmodule

// File: rtl/sd_out.sv
`timescale 1ns/1ps
module sd_out
    import seqdet_pkg::*;
(
    input  sd_state_e cur,
    input  logic      bit_in,
    output logic      hit_reg,
    output logic      hit_comb
);
    always_comb begin
        hit_reg  = (cur == ST_HIT);
        hit_comb = (cur == ST_M6) && bit_in;
    end
endmodule

// File: rtl/serial_pattern_detect.sv
`timescale 1ns/1ps
module serial_pattern_detect
    import seqdet_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            din,
    output logic            det_reg,
    output logic            det_comb,
    output logic [ST_W-1:0] state_code
);
    sd_regs_t  regs_d, regs_q;
    sd_state_e step_nxt;

    sd_next u_next (
        .cur    (regs_q.state),
        .bit_in (din),
        .nxt    (step_nxt)
    );

    sd_out u_out (
        .cur      (regs_q.state),
        .bit_in   (din),
        .hit_reg  (det_reg),
        .hit_comb (det_comb)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) regs_d.state = ST_M0;
        else     regs_d.state = step_nxt;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state_code = regs_q.state;

    // R1 and R7: a reset edge always lands in code 000, whatever din is.
    a_r1_reset_to_idle: assert property (@(posedge clk)
        rst |=> (state_code == 3'b000) && !det_reg);

    // R3: the registered flag echoes the combinational flag one cycle later.
    a_r3_reg_follows_comb: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (det_reg == $past(det_comb)));

    // R2: an accepted completing bit always moves the machine to the full-match code.
    a_r2_comb_leads_to_hit: assert property (@(posedge clk) disable iff (rst)
        det_comb |=> (state_code == 3'b100));

    // R4: a 0 after a full match keeps four matched bits (0110).
    a_r4_overlap_zero: assert property (@(posedge clk) disable iff (rst)
        (det_reg && !din) |=> (state_code == 3'b010));

    // R4: a 1 after a full match leaves nothing matched.
    a_r4_overlap_one: assert property (@(posedge clk) disable iff (rst)
        (det_reg && din) |=> (state_code == 3'b000));

    // R6: the two flags never coincide.
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({det_reg, det_comb}));
endmodule

// File: tb/tb_serial_pattern_detect.sv
`timescale 1ns/1ps
module tb_serial_pattern_detect;
    localparam logic [6:0] PAT = 7'b0110011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic det_reg, det_comb;
    logic [2:0] state_code;

    int total = 0;
    int bad = 0;
    logic [6:0] hist = '0;   // newest accepted bit at position 0
    int hcount = 0;
    logic exp_reg = 1'b0;
    int comb_seen = 0;
    int reg_seen = 0;
    int obs_code = 0;
    int code_of [8] = '{0, 7, 5, 1, 2, 6, 3, 4};

    always #2 clk = ~clk;   // 250 MHz

    serial_pattern_detect dut (
        .clk(clk), .rst(rst), .din(din),
        .det_reg(det_reg), .det_comb(det_comb), .state_code(state_code)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic int match_len();
        for (int k = 7; k >= 1; k--) begin
            if (hcount >= k) begin
                logic [6:0] mask;
                mask = 7'((8'd1 << k) - 1);
                if ((hist & mask) == (PAT >> (7 - k))) return k;
            end
        end
        return 0;
    endfunction

    task automatic step(input logic b);
        int  k;
        logic exp_comb;
        @(negedge clk);
        din = b;
        #1;
        k = match_len();
        exp_comb = (hcount >= 6) && ({hist[5:0], b} == PAT);
        obs_code = int'(state_code);
        check(state_code == 3'(code_of[k]), "R5 state code", int'(state_code), code_of[k]);
        check(det_comb == exp_comb, "R2 comb flag", int'(det_comb), int'(exp_comb));
        check(det_reg == exp_reg, "R3 reg flag", int'(det_reg), int'(exp_reg));
        check(!(det_reg && det_comb), "R6 exclusive", int'({det_reg, det_comb}), 0);
        if (det_comb) comb_seen++;
        if (det_reg) reg_seen++;
        exp_reg = exp_comb;
        hist = {hist[5:0], b};
        if (hcount < 7) hcount++;
    endtask

    task automatic feed(input logic [6:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) step(v[i]);
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            din = 1'($urandom);
        end
        #1;
        // R7: bits driven during reset leave the state at code 000.
        check(state_code == 3'b000, "R7 reset ignores din", int'(state_code), 0);
        check(det_reg == 1'b0, "R1 reg flag in reset", int'(det_reg), 0);
        check(det_comb == 1'b0, "R1 comb flag in reset", int'(det_comb), 0);
        @(negedge clk);
        din = 1'b1;
        #1;
        check(state_code == 3'b000, "R1 reset state", int'(state_code), 0);
        rst = 1'b0;
        hist = '0;
        hcount = 0;
        exp_reg = 1'b0;
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(3);

        // R4: overlapping chain 0110011 0011 0011 gives three detections.
        comb_seen = 0;
        reg_seen = 0;
        feed(PAT, 7);
        step(1'b0);
        step(1'b0);
        check(obs_code == 2, "R4 code after match then 0", obs_code, 2);
        feed(7'b0000011, 2);
        feed(7'b0000011, 4);
        step(1'b1);
        check(comb_seen == 3, "R4 comb detections", comb_seen, 3);
        check(reg_seen == 3, "R4 reg detections", reg_seen, 3);

        // R7: a reset in mid-pattern discards the partial match.
        feed(7'b0011001, 6);
        do_reset(2);
        comb_seen = 0;
        step(1'b1);
        check(comb_seen == 0, "R7 no match across reset", comb_seen, 0);

        // Random streams with embedded single and overlapping matches.
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 0) feed(PAT, 7);
            else if (r == 1) begin
                feed(PAT, 7);
                feed(7'b0000011, 4);
            end else step(1'($urandom));
        end

        do_reset(2);
        step(1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule